// File: doc/BRIEF.md
# Calendar Real-Time-Clock Register Block

This block is a memory-mapped real-time clock on a simple 32-bit register bus. It keeps a packed date word and a packed time word, and each pulse on a one-second tick input advances them through the seconds, minutes, hours, weekday, day, month and year fields. It also keeps a bank of general-purpose scratch words.

Writing the date or time word raises a sticky flag in a control/status word. Reading the control word returns the flags and clears them in the same access. A parameter picks one of two register-address layouts, and each layout has its own scratch count. On reset the date and time words load from two preset inputs.

The bus takes one access per cycle. It uses byte addresses inside a 1 KiB window, and only word-aligned offsets are decoded. Read data is registered.

Top module: `cal_rtc_regs`

## Requirements
- R1: On reset the date word loads `preset_date`, the time word loads `preset_time`, both sticky flags and every scratch word clear to zero, and `bus_rdata` is zero.
- R2: A write to the date offset stores the 32-bit value and sets control bit 7. A write to the time offset stores the value and sets control bit 8.
- R3: A read of the control word (offset 0x000) returns bit 7 (date written) and bit 8 (time written), with all other bits zero. The same read clears both flags, so a second read returns 0. Writes to the control word have no effect.
- R4: With `LAYOUT`=0 the date word is at 0x004, the time word at 0x008, and four scratch words at 0x020, 0x024, 0x028 and 0x02C.
- R5: With `LAYOUT`=1 the date word is at 0x010, the time word at 0x014, and eight scratch words run from 0x100 to 0x11C in steps of 4. Offsets used only by the other layout are unmapped.
- R6: A read of an unmapped offset, or of any offset with bits 1:0 not zero, returns 0. A write to such an offset changes no register and no flag.
- R7: Each scratch word returns the last 32-bit value written to it.
- R8: The time word packs the weekday in bits 31:29 (0 = Monday to 6 = Sunday), the hour in 23:16, the minute in 15:8 and the second in 7:0. Each tick adds one second. A second of 59 wraps to 0 and carries into the minute, a minute of 59 wraps and carries into the hour, and an hour of 23 wraps and carries into the day.
- R9: On each day carry the weekday advances by one, and Sunday (6) wraps to Monday (0).
- R10: The date word packs the year offset in bits 31:16, the month (1 to 12) in 15:8 and the day in 7:0. The day wraps to 1 after the month's last day. April, June, September and November have 30 days, other months 31, and February has 29 when the year offset is divisible by 4, otherwise 28. Month 12 wraps to 1 and increments the year offset.
- R11: When a bus write to the date or time word comes in the same cycle as a tick, the written value is stored and that tick is dropped for both words.
- R12: `bus_rdata` presents the read word after the clock edge that accepts the read, and holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick | input | 1 | One-second advance pulse |
| preset_date | input | 32 | Date word loaded at reset |
| preset_time | input | 32 | Time word loaded at reset |

## Verification
A register write takes effect at the clock edge that accepts it. A read presents its word on `bus_rdata` after that same edge, and the control-flag clear also happens at that edge. A tick changes the counters at the edge where it is high. The bench drives each access or tick on a falling edge and removes it on the next falling edge. It samples `bus_rdata` at that falling edge, half a period after the edge that updated it. Every calendar result is observed through a later read, so no check depends on the ordering of processes at a clock edge.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;
  localparam int WORD_W        = 32;
  localparam int FLAG_DATE_BIT = 7;
  localparam int FLAG_TIME_BIT = 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_DATE,
    SEL_TIME,
    SEL_SCR
  } reg_sel_e;

  // Per-layout address map; layout 0 is compact, layout 1 is wide.
  function automatic int unsigned date_off(input int unsigned layout);
    return (layout == 0) ? 32'h004 : 32'h010;
  endfunction

  function automatic int unsigned time_off(input int unsigned layout);
    return (layout == 0) ? 32'h008 : 32'h014;
  endfunction

  function automatic int unsigned scr_base(input int unsigned layout);
    return (layout == 0) ? 32'h020 : 32'h100;
  endfunction

  function automatic int unsigned scr_num(input int unsigned layout);
    return (layout == 0) ? 4 : 8;
  endfunction

  // Days in a month; out-of-range months count as 31 days.
  function automatic logic [7:0] month_len(input logic [7:0] month, input logic leap);
    logic [7:0] len;
    case (month)
      8'd2:                      len = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   len = 8'd30;
      default:                   len = 8'd31;
    endcase
    return len;
  endfunction
endpackage

// File: rtl/cal_rtc_decode.sv
module cal_rtc_decode
  import cal_rtc_pkg::*;
#(
  parameter int LAYOUT = 0,
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  scr_idx
);
  localparam logic [ADDR_W-1:0] CTRL_A = '0;
  localparam logic [ADDR_W-1:0] DATE_A = ADDR_W'(date_off(LAYOUT));
  localparam logic [ADDR_W-1:0] TIME_A = ADDR_W'(time_off(LAYOUT));
  localparam logic [ADDR_W-1:0] SCR_A  = ADDR_W'(scr_base(LAYOUT));
  localparam logic [ADDR_W:0]   SCR_E  = (ADDR_W+1)'(scr_base(LAYOUT) + 4 * scr_num(LAYOUT));

  logic [ADDR_W-1:0] scr_rel;
  logic              aligned;
  logic              in_scr;

  assign aligned = (addr[1:0] == 2'b00);
  assign scr_rel = addr - SCR_A;
  assign scr_idx = IDX_W'(scr_rel >> 2);
  assign in_scr  = (addr >= SCR_A) && ({1'b0, addr} < SCR_E);

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      if (addr == CTRL_A)      sel = SEL_CTRL;
      else if (addr == DATE_A) sel = SEL_DATE;
      else if (addr == TIME_A) sel = SEL_TIME;
      else if (in_scr)         sel = SEL_SCR;
    end
  end
endmodule

// File: rtl/cal_rtc_calendar.sv
module cal_rtc_calendar
  import cal_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] preset_date,
  input  logic [WORD_W-1:0] preset_time,
  input  logic              tick,
  input  logic              wr_date,
  input  logic              wr_time,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] date_q,
  output logic [WORD_W-1:0] time_q
);
  logic [7:0]  sec, mnt, hr, day, mon;
  logic [2:0]  wday;
  logic [15:0] yr;
  logic        s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap;
  logic [WORD_W-1:0] nxt_date, nxt_time;

  assign sec  = time_q[7:0];
  assign mnt  = time_q[15:8];
  assign hr   = time_q[23:16];
  assign wday = time_q[31:29];
  assign day  = date_q[7:0];
  assign mon  = date_q[15:8];
  assign yr   = date_q[31:16];

  assign s_wrap  = (sec >= 8'd59);
  assign m_wrap  = (mnt >= 8'd59);
  assign h_wrap  = (hr >= 8'd23);
  assign d_wrap  = (day >= month_len(mon, yr[1:0] == 2'b00));
  assign mo_wrap = (mon >= 8'd12);

  always_comb begin
    nxt_time = time_q;
    nxt_date = date_q;
    nxt_time[7:0] = s_wrap ? 8'd0 : sec + 8'd1;
    if (s_wrap) begin
      nxt_time[15:8] = m_wrap ? 8'd0 : mnt + 8'd1;
      if (m_wrap) begin
        nxt_time[23:16] = h_wrap ? 8'd0 : hr + 8'd1;
        if (h_wrap) begin
          nxt_time[31:29] = (wday >= 3'd6) ? 3'd0 : wday + 3'd1;
          nxt_date[7:0]   = d_wrap ? 8'd1 : day + 8'd1;
          if (d_wrap) begin
            nxt_date[15:8] = mo_wrap ? 8'd1 : mon + 8'd1;
            if (mo_wrap) nxt_date[31:16] = yr + 16'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      date_q <= preset_date;
      time_q <= preset_time;
    end else if (wr_date || wr_time) begin
      if (wr_date) date_q <= wdata;
      if (wr_time) time_q <= wdata;
    end else if (tick) begin
      date_q <= nxt_date;
      time_q <= nxt_time;
    end
  end
endmodule

// File: rtl/cal_rtc_scratch.sv
module cal_rtc_scratch #(
  parameter int NUM   = 4,
  parameter int IDX_W = 2,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                   mem[g] <= '0;
      else if (we && (idx == IDX_W'(g)))         mem[g] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/cal_rtc_regs.sv
module cal_rtc_regs
  import cal_rtc_pkg::*;
#(
  parameter int LAYOUT = 0,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick,
  input  logic [31:0]       preset_date,
  input  logic [31:0]       preset_time
);
  localparam int SCR_NUM = scr_num(LAYOUT);
  localparam int IDX_W   = $clog2(SCR_NUM);

  reg_sel_e          sel;
  logic [IDX_W-1:0]  scr_idx;
  logic              acc_wr, acc_rd;
  logic              flag_date, flag_time;
  logic [31:0]       date_q, time_q, scr_word;
  logic [31:0]       ctrl_word, rd_mux;

  assign acc_wr = bus_en && bus_we;
  assign acc_rd = bus_en && !bus_we;

  cal_rtc_decode #(.LAYOUT(LAYOUT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
    .addr(bus_addr), .sel(sel), .scr_idx(scr_idx)
  );

  cal_rtc_calendar u_calendar (
    .clk(clk), .rst(rst),
    .preset_date(preset_date), .preset_time(preset_time),
    .tick(tick),
    .wr_date(acc_wr && (sel == SEL_DATE)),
    .wr_time(acc_wr && (sel == SEL_TIME)),
    .wdata(bus_wdata),
    .date_q(date_q), .time_q(time_q)
  );

  cal_rtc_scratch #(.NUM(SCR_NUM), .IDX_W(IDX_W), .DW(WORD_W)) u_scratch (
    .clk(clk), .rst(rst),
    .we(acc_wr && (sel == SEL_SCR)),
    .idx(scr_idx), .wdata(bus_wdata), .rdata(scr_word)
  );

  // Sticky write-pending flags, cleared by a control read.
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_date <= 1'b0;
      flag_time <= 1'b0;
    end else if (acc_rd && (sel == SEL_CTRL)) begin
      flag_date <= 1'b0;
      flag_time <= 1'b0;
    end else if (acc_wr) begin
      if (sel == SEL_DATE) flag_date <= 1'b1;
      if (sel == SEL_TIME) flag_time <= 1'b1;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[FLAG_DATE_BIT] = flag_date;
    ctrl_word[FLAG_TIME_BIT] = flag_time;
  end

  always_comb begin
    case (sel)
      SEL_CTRL: rd_mux = ctrl_word;
      SEL_DATE: rd_mux = date_q;
      SEL_TIME: rd_mux = time_q;
      SEL_SCR:  rd_mux = scr_word;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (acc_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/cal_rtc_checker.sv
module cal_rtc_checker
  import cal_rtc_pkg::*;
#(
  parameter int LAYOUT = 0,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              tick,
  input logic [31:0]       date_q,
  input logic [31:0]       time_q,
  input logic              flag_date,
  input logic              flag_time
);
  localparam logic [ADDR_W-1:0] DATE_A = ADDR_W'(date_off(LAYOUT));
  localparam logic [ADDR_W-1:0] TIME_A = ADDR_W'(time_off(LAYOUT));

  logic wr_d, wr_t, rd_c;
  assign wr_d = bus_en && bus_we && (bus_addr == DATE_A);
  assign wr_t = bus_en && bus_we && (bus_addr == TIME_A);
  assign rd_c = bus_en && !bus_we && (bus_addr == '0);

  p_date_store_r2: assert property (@(posedge clk) disable iff (rst)
    wr_d |=> flag_date && (date_q == $past(bus_wdata)));

  p_time_store_r2: assert property (@(posedge clk) disable iff (rst)
    wr_t |=> flag_time && (time_q == $past(bus_wdata)));

  p_ctrl_clear_r3: assert property (@(posedge clk) disable iff (rst)
    rd_c |=> !flag_date && !flag_time &&
             (bus_rdata[8:7] == {$past(flag_time), $past(flag_date)}));

  p_sec_step_r8: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_d && !wr_t && (time_q[7:0] < 8'd59)) |=>
      (time_q[7:0] == $past(time_q[7:0]) + 8'd1));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!tick && !(bus_en && bus_we)) |=> $stable(time_q) && $stable(date_q));

  p_write_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (tick && wr_t && !wr_d) |=> (time_q == $past(bus_wdata)) && $stable(date_q));

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && !bus_we) |=> $stable(bus_rdata));
endmodule

bind cal_rtc_regs cal_rtc_checker #(.LAYOUT(LAYOUT), .ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
  .date_q(date_q), .time_q(time_q), .flag_date(flag_date), .flag_time(flag_time)
);

// File: tb/test_cal_rtc_regs.sv
module test_cal_rtc_regs;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_a = 1'b0, en_b = 1'b0, we = 1'b0, tick_a = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  int total = 0, bad = 0;
  bit done = 1'b0;

  function automatic logic [31:0] tw(int wd, int h, int m, int s);
    return {wd[2:0], 5'b0, h[7:0], m[7:0], s[7:0]};
  endfunction
  function automatic logic [31:0] dw(int y, int m, int d);
    return {y[15:0], m[7:0], d[7:0]};
  endfunction

  localparam logic [31:0] PRE_DATE = {16'd5, 8'd2, 8'd28};
  localparam logic [31:0] PRE_TIME = {3'd6, 5'b0, 8'd23, 8'd59, 8'd58};

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_rtc_regs #(.LAYOUT(0), .ADDR_W(ADDR_W)) i_cal_rtc_regs (
    .clk(clk), .rst(rst), .bus_en(en_a), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata_a), .tick(tick_a),
    .preset_date(PRE_DATE), .preset_time(PRE_TIME)
  );

  cal_rtc_regs #(.LAYOUT(1), .ADDR_W(ADDR_W)) i_cal_rtc_regs_b (
    .clk(clk), .rst(rst), .bus_en(en_b), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata_b), .tick(1'b0),
    .preset_date(32'h0), .preset_time(32'h0)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(bit b, logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1; en_a = !b; en_b = b;
    @(negedge clk);
    en_a = 1'b0; en_b = 1'b0; we = 1'b0;
  endtask

  task automatic rd(bit b, logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0; en_a = !b; en_b = b;
    @(negedge clk);
    en_a = 1'b0; en_b = 1'b0;
    d = b ? rdata_b : rdata_a;
  endtask

  task automatic rd_chk(bit b, logic [ADDR_W-1:0] a, logic [31:0] exp, string req);
    logic [31:0] v;
    rd(b, a, v);
    check(req, v, exp);
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick_a = 1'b1;
    @(negedge clk);
    tick_a = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rdata after reset", rdata_a, 32'h0);
    rd_chk(0, 10'h004, PRE_DATE, "R1 preset date");
    rd_chk(0, 10'h008, PRE_TIME, "R1 preset time");
    rd_chk(0, 10'h000, 32'h0, "R1 flags clear");
    rd_chk(0, 10'h024, 32'h0, "R1 scratch clear");
    rd_chk(1, 10'h11C, 32'h0, "R1 scratch clear layout 1");
  endtask

  task automatic t_flags();
    logic [31:0] v;
    wr(0, 10'h004, dw(1, 1, 1));
    rd_chk(0, 10'h000, 32'h80, "R2 date flag bit 7");
    rd_chk(0, 10'h000, 32'h0, "R3 second read clear");
    wr(0, 10'h008, tw(0, 1, 2, 3));
    rd_chk(0, 10'h000, 32'h100, "R2 time flag bit 8");
    wr(0, 10'h004, dw(2, 2, 2));
    wr(0, 10'h008, tw(1, 2, 3, 4));
    rd_chk(0, 10'h000, 32'h180, "R3 both flags");
    rd_chk(0, 10'h000, 32'h0, "R3 both cleared");
    wr(0, 10'h000, 32'hFFFF_FFFF);
    rd_chk(0, 10'h000, 32'h0, "R3 control write ignored");
    rd(0, 10'h004, v);
    check("R2 date stored", v, dw(2, 2, 2));
    // R12: rdata holds with no read in progress
    @(negedge clk);
    @(negedge clk);
    check("R12 rdata hold", rdata_a, dw(2, 2, 2));
  endtask

  task automatic t_layout_a();
    for (int i = 0; i < 4; i++) wr(0, ADDR_W'(32'h020 + 4*i), 32'hA500_0000 + i);
    for (int i = 0; i < 4; i++)
      rd_chk(0, ADDR_W'(32'h020 + 4*i), 32'hA500_0000 + i, "R4 R7 scratch layout 0");
    rd_chk(0, 10'h010, 32'h0, "R4 0x010 unmapped in layout 0");
    rd_chk(0, 10'h100, 32'h0, "R4 0x100 unmapped in layout 0");
  endtask

  task automatic t_layout_b();
    wr(1, 10'h010, dw(9, 8, 7));
    wr(1, 10'h014, tw(3, 4, 5, 6));
    rd_chk(1, 10'h010, dw(9, 8, 7), "R5 date at 0x010");
    rd_chk(1, 10'h014, tw(3, 4, 5, 6), "R5 time at 0x014");
    rd_chk(1, 10'h000, 32'h180, "R5 flags layout 1");
    for (int i = 0; i < 8; i++) wr(1, ADDR_W'(32'h100 + 4*i), 32'h5A00_1000 * (i + 1));
    for (int i = 0; i < 8; i++)
      rd_chk(1, ADDR_W'(32'h100 + 4*i), 32'h5A00_1000 * (i + 1), "R5 R7 scratch layout 1");
    wr(1, 10'h004, 32'h1234_5678);
    rd_chk(1, 10'h004, 32'h0, "R5 0x004 unmapped in layout 1");
    rd_chk(1, 10'h020, 32'h0, "R5 0x020 unmapped in layout 1");
    rd_chk(1, 10'h010, dw(9, 8, 7), "R5 date untouched");
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(0, 10'h000, v);
    wr(0, 10'h00C, 32'hFFFF_FFFF);
    wr(0, 10'h030, 32'hFFFF_FFFF);
    wr(0, 10'h3FC, 32'hFFFF_FFFF);
    wr(0, 10'h005, 32'hDEAD_BEEF);
    wr(0, 10'h022, 32'hDEAD_BEEF);
    rd_chk(0, 10'h00C, 32'h0, "R6 unmapped 0x00C");
    rd_chk(0, 10'h030, 32'h0, "R6 unmapped 0x030");
    rd_chk(0, 10'h3FC, 32'h0, "R6 unmapped 0x3FC");
    rd_chk(0, 10'h005, 32'h0, "R6 unaligned read");
    rd_chk(0, 10'h004, dw(2, 2, 2), "R6 unaligned write ignored");
    rd_chk(0, 10'h020, 32'hA500_0000, "R6 scratch untouched");
    rd_chk(0, 10'h000, 32'h0, "R6 no flag from bad write");
  endtask

  task automatic t_seconds();
    wr(0, 10'h004, dw(7, 6, 15));
    wr(0, 10'h008, tw(1, 10, 59, 58));
    pulse_tick();
    rd_chk(0, 10'h008, tw(1, 10, 59, 59), "R8 second step");
    pulse_tick();
    rd_chk(0, 10'h008, tw(1, 11, 0, 0), "R8 minute and hour carry");
    rd_chk(0, 10'h004, dw(7, 6, 15), "R8 date unchanged");
  endtask

  task automatic roll(int y, int mo, int d, int wd, int ey, int emo, int ed, string req);
    wr(0, 10'h004, dw(y, mo, d));
    wr(0, 10'h008, tw(wd, 23, 59, 59));
    pulse_tick();
    rd_chk(0, 10'h004, dw(ey, emo, ed), req);
    rd_chk(0, 10'h008, tw((wd + 1) % 7, 0, 0, 0), "R9 weekday after day carry");
  endtask

  task automatic t_day_month();
    roll(3, 2, 28, 6, 3, 3, 1, "R10 non-leap Feb 28 wraps");
    roll(4, 2, 28, 2, 4, 2, 29, "R10 leap Feb 29 exists");
    roll(4, 2, 29, 3, 4, 3, 1, "R10 leap Feb 29 wraps");
    roll(9, 4, 30, 0, 9, 5, 1, "R10 30-day month wraps");
    roll(9, 1, 30, 4, 9, 1, 31, "R10 31-day month day 31");
    roll(9, 1, 31, 5, 9, 2, 1, "R10 31-day month wraps");
    roll(9, 12, 31, 6, 10, 1, 1, "R10 year carry");
  endtask

  task automatic t_collision();
    wr(0, 10'h004, dw(1, 1, 1));
    wr(0, 10'h008, tw(0, 0, 0, 5));
    @(negedge clk);
    addr = 10'h008; wdata = tw(2, 3, 4, 5); we = 1'b1; en_a = 1'b1; tick_a = 1'b1;
    @(negedge clk);
    en_a = 1'b0; we = 1'b0; tick_a = 1'b0;
    rd_chk(0, 10'h008, tw(2, 3, 4, 5), "R11 time write wins");
    rd_chk(0, 10'h004, dw(1, 1, 1), "R11 date not advanced");
    wr(0, 10'h008, tw(0, 23, 59, 59));
    @(negedge clk);
    addr = 10'h004; wdata = dw(2, 2, 2); we = 1'b1; en_a = 1'b1; tick_a = 1'b1;
    @(negedge clk);
    en_a = 1'b0; we = 1'b0; tick_a = 1'b0;
    rd_chk(0, 10'h004, dw(2, 2, 2), "R11 date write wins");
    rd_chk(0, 10'h008, tw(0, 23, 59, 59), "R11 time tick dropped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_flags();
    t_layout_a();
    t_layout_b();
    t_unmapped();
    t_seconds();
    t_day_month();
    t_collision();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule